// File: doc/BRIEF.md
# Interrupt Distributor with Claim Interface

This block collects level-sensitive interrupt request lines and presents at most one of them to a single processor. Each line has an enable bit, a software pending latch, an active bit and an 8-bit priority. Smaller priority values are more urgent. A global distribution switch gates all lines. A processor-side switch and a priority mask gate the single interrupt output.

Software drives the block through a 32-bit register port. The port has separate write and read address buses, so that one register write and one register read can take place in the same cycle. Read data is combinational from the state held before the clock edge. Side effects of a read, and all writes, take effect at that edge.

To claim the most urgent forwardable line, the processor reads the acknowledge register. The claimed line becomes active and cannot be claimed again until its ID is written to the end-of-interrupt register. A claim with nothing forwardable returns the spurious ID 1023. A line whose priority is not below the current running priority is held back, so that only a more urgent line can interrupt the one being serviced.

Top module: `irq_distributor`

## Requirements
- R1: After reset, all of these are cleared: enables, software pending latches, active bits, priorities, both control switches and the mask. `irq_out` is 0, the running-priority register (0x1014) reads 0xFF and the acknowledge register (0x100C) reads 1023. Address bit 12 selects the processor-side registers; when it is 0 the distributor registers are selected.
- R2: The distributor type register (0x004) returns NUM_LINES/32-1 in bits [4:0].
- R3: Line k maps to bit k%32 of enable word k/32. Writing a 1 to that bit at 0x100+4·word enables the line, and writing a 1 at 0x180+4·word disables it. Writing 0 bits has no effect. Both offsets read back the current enable word.
- R4: The priority of line k sits in byte k%4, bits [8(k%4)+7 : 8(k%4)], of the word at 0x400+4·(k/4), and reads back from the same place.
- R5: `irq_out` is 1 when all of these hold: bit 0 of distributor control (0x000) is set, bit 0 of processor control (0x1000) is set, and some line is enabled, pending and not active, with a priority below both the mask (0x1004, bits [7:0]) and the running priority. Otherwise `irq_out` is 0.
- R6: Among the lines that qualify, the lowest priority value wins. On equal priority, the lower ID wins.
- R7: A read of 0x100C returns the ID of the winning line in bits [9:0], with the upper bits zero, when `irq_out` is 1. Otherwise it returns 1023 and changes no state. A successful claim marks the line active and clears its software pending latch.
- R8: An active line cannot be claimed again. Writing its ID to 0x1010 clears its active bit. An end-of-interrupt write with an ID of NUM_LINES or more has no effect.
- R9: The running-priority register (0x1014) returns the lowest priority among active lines, or 0xFF when no line is active.
- R10: The pending word at 0x200+4·word reads as the OR of the request inputs and the software latches. A 1 written there sets the latch, and a 1 written at 0x280+4·word clears it.
- R11: A 1 written at 0x380+4·word clears the active bit of that line. Reads at that offset return the active word.
- R12: The highest-pending register (0x1018) returns the ID of the most urgent line that is enabled, pending and not active while distribution is on. This ignores the mask, the running priority and the processor switch. It returns 1023 when no such line exists.
- R13: A claim read and a register write in the same cycle both take effect. The read data reflects the state held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt requests |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 13 | Write byte address; bit 12 selects processor side |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (side effects on acknowledge) |
| rd_addr | input | 13 | Read byte address; bit 12 selects processor side |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 1 | Interrupt signal to the processor |

## Verification
The critical overlap is a claim read and an end-of-interrupt write landing on the same edge. In that cycle one line is released while another moves to active, and the running priority must reflect only the newly claimed line afterwards. The bench provokes this by holding line 5 active and raising a more urgent line 63. It then issues the acknowledge read and the release of line 5 in one cycle. The bench judges the outcome from the returned ID (63), the running priority (0x10) that follows, and the active words read back afterwards.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   irq_id_t;

    localparam irq_id_t SPURIOUS_ID = 10'h3FF;
    localparam prio_t   PRIO_IDLE   = 8'hFF;

    // distributor-side offsets (address bit 12 clear)
    localparam logic [11:0] OFF_DCTRL = 12'h000;
    localparam logic [11:0] OFF_DTYPE = 12'h004;
    // processor-side offsets (address bit 12 set)
    localparam logic [11:0] OFF_CCTRL = 12'h000;
    localparam logic [11:0] OFF_CMASK = 12'h004;
    localparam logic [11:0] OFF_CACK  = 12'h00C;
    localparam logic [11:0] OFF_CEOI  = 12'h010;
    localparam logic [11:0] OFF_CRUN  = 12'h014;
    localparam logic [11:0] OFF_CHPP  = 12'h018;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_SET_EN,
        GRP_CLR_EN,
        GRP_SET_PEND,
        GRP_CLR_PEND,
        GRP_CLR_ACT,
        GRP_PRIO
    } dist_grp_e;

    function automatic dist_grp_e dist_group(input logic [11:0] off);
        dist_grp_e g;
        g = GRP_NONE;
        if (off[11:10] == 2'b01) begin
            g = GRP_PRIO;
        end else begin
            case (off[11:7])
                5'h02:   g = GRP_SET_EN;
                5'h03:   g = GRP_CLR_EN;
                5'h04:   g = GRP_SET_PEND;
                5'h05:   g = GRP_CLR_PEND;
                5'h07:   g = GRP_CLR_ACT;
                default: g = GRP_NONE;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/irqd_line_bank.sv
module irqd_line_bank
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_dist,
    input  dist_grp_e                   wr_grp,
    input  logic [11:0]                 wr_off,
    input  logic [31:0]                 wdata,
    input  logic                        claim_valid,
    input  irq_id_t                     claim_id,
    input  logic                        eoi_valid,
    input  irq_id_t                     eoi_id,
    output logic [NUM_LINES-1:0]        enable_q,
    output logic [NUM_LINES-1:0]        swpend_q,
    output logic [NUM_LINES-1:0]        active_q,
    output logic [NUM_LINES*PRIO_W-1:0] prio_q
);
    localparam int NUM_WORDS = NUM_LINES / 32;
    localparam int NUM_QUADS = NUM_LINES / 4;

    logic [4:0] word_idx;
    logic [7:0] quad_idx;
    assign word_idx = wr_off[6:2];
    assign quad_idx = wr_off[9:2];

    logic [NUM_LINES-1:0] set_en_m, clr_en_m, set_pd_m, clr_pd_m, clr_act_m;
    logic [NUM_LINES-1:0] claim_m, eoi_m;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = wr_dist && (word_idx == 5'(w));
        assign set_en_m[w*32 +: 32]  = (hit && wr_grp == GRP_SET_EN)   ? wdata : '0;
        assign clr_en_m[w*32 +: 32]  = (hit && wr_grp == GRP_CLR_EN)   ? wdata : '0;
        assign set_pd_m[w*32 +: 32]  = (hit && wr_grp == GRP_SET_PEND) ? wdata : '0;
        assign clr_pd_m[w*32 +: 32]  = (hit && wr_grp == GRP_CLR_PEND) ? wdata : '0;
        assign clr_act_m[w*32 +: 32] = (hit && wr_grp == GRP_CLR_ACT)  ? wdata : '0;
    end

    always_comb begin
        for (int k = 0; k < NUM_LINES; k++) begin
            claim_m[k] = claim_valid && (claim_id == irq_id_t'(k));
            eoi_m[k]   = eoi_valid && (eoi_id == irq_id_t'(k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            swpend_q <= '0;
            active_q <= '0;
        end else begin
            enable_q <= (enable_q | set_en_m) & ~clr_en_m;
            swpend_q <= (swpend_q | set_pd_m) & ~clr_pd_m & ~claim_m;
            active_q <= (active_q & ~clr_act_m & ~eoi_m) | claim_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
        end else begin
            for (int q = 0; q < NUM_QUADS; q++) begin
                if (wr_dist && wr_grp == GRP_PRIO && quad_idx == 8'(q)) begin
                    prio_q[q*32 +: 32] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic [NUM_LINES-1:0]        req,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        pick_valid,
    output irq_id_t                     pick_id,
    output prio_t                       pick_prio
);
    // ascending scan with strict compare keeps the lower ID on ties
    always_comb begin
        pick_valid = 1'b0;
        pick_id    = SPURIOUS_ID;
        pick_prio  = PRIO_IDLE;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (req[k] && (!pick_valid || prio_flat[k*PRIO_W +: PRIO_W] < pick_prio)) begin
                pick_valid = 1'b1;
                pick_id    = irq_id_t'(k);
                pick_prio  = prio_flat[k*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irqd_minprio.sv
module irqd_minprio
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic [NUM_LINES-1:0]        sel,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output prio_t                       min_prio
);
    always_comb begin
        min_prio = PRIO_IDLE;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (sel[k] && prio_flat[k*PRIO_W +: PRIO_W] < min_prio) begin
                min_prio = prio_flat[k*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 wr_en,
    input  logic [12:0]          wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    input  logic [12:0]          rd_addr,
    output logic [31:0]          rd_data,
    output logic                 irq_out
);
    localparam int NUM_WORDS = NUM_LINES / 32;
    localparam int NUM_QUADS = NUM_LINES / 4;

    logic [11:0] wr_off, rd_off;
    logic        wr_cpu, rd_cpu, wr_dist;
    dist_grp_e   wr_grp, rd_grp;

    assign wr_off  = wr_addr[11:0];
    assign rd_off  = rd_addr[11:0];
    assign wr_cpu  = wr_addr[12];
    assign rd_cpu  = rd_addr[12];
    assign wr_dist = wr_en && !wr_cpu;
    assign wr_grp  = dist_group(wr_off);
    assign rd_grp  = dist_group(rd_off);

    // control registers
    logic  dist_en_q, cpu_en_q;
    prio_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_en_q <= 1'b0;
            cpu_en_q  <= 1'b0;
            mask_q    <= '0;
        end else if (wr_en) begin
            if (!wr_cpu && wr_off == OFF_DCTRL) dist_en_q <= wr_data[0];
            if (wr_cpu && wr_off == OFF_CCTRL)  cpu_en_q  <= wr_data[0];
            if (wr_cpu && wr_off == OFF_CMASK)  mask_q    <= wr_data[PRIO_W-1:0];
        end
    end

    // per-line state
    logic [NUM_LINES-1:0]        enable_q, swpend_q, active_q;
    logic [NUM_LINES*PRIO_W-1:0] prio_q;
    logic                        claim_valid, eoi_valid;
    irq_id_t                     best_id;
    logic                        best_valid;
    prio_t                       best_prio, run_prio;

    assign eoi_valid = wr_en && wr_cpu && (wr_off == OFF_CEOI);

    irqd_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_dist     (wr_dist),
        .wr_grp      (wr_grp),
        .wr_off      (wr_off),
        .wdata       (wr_data),
        .claim_valid (claim_valid),
        .claim_id    (best_id),
        .eoi_valid   (eoi_valid),
        .eoi_id      (wr_data[ID_W-1:0]),
        .enable_q    (enable_q),
        .swpend_q    (swpend_q),
        .active_q    (active_q),
        .prio_q      (prio_q)
    );

    logic [NUM_LINES-1:0] pend_eff, cand;
    assign pend_eff = irq_lines | swpend_q;
    assign cand     = enable_q & pend_eff & ~active_q & {NUM_LINES{dist_en_q}};

    irqd_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .req        (cand),
        .prio_flat  (prio_q),
        .pick_valid (best_valid),
        .pick_id    (best_id),
        .pick_prio  (best_prio)
    );

    irqd_minprio #(.NUM_LINES(NUM_LINES)) u_run (
        .sel       (active_q),
        .prio_flat (prio_q),
        .min_prio  (run_prio)
    );

    logic fwd, ack_rd;
    assign fwd         = cpu_en_q && best_valid && (best_prio < mask_q) && (best_prio < run_prio);
    assign irq_out     = fwd;
    assign ack_rd      = rd_en && rd_cpu && (rd_off == OFF_CACK);
    assign claim_valid = ack_rd && fwd;

    // read word selection
    logic [31:0] en_word, pd_word, act_word, prio_word;

    always_comb begin
        en_word   = '0;
        pd_word   = '0;
        act_word  = '0;
        prio_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_off[6:2] == 5'(w)) begin
                en_word  = enable_q[w*32 +: 32];
                pd_word  = pend_eff[w*32 +: 32];
                act_word = active_q[w*32 +: 32];
            end
        end
        for (int q = 0; q < NUM_QUADS; q++) begin
            if (rd_off[9:2] == 8'(q)) prio_word = prio_q[q*32 +: 32];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_cpu) begin
            case (rd_off)
                OFF_CCTRL: rd_data[0]          = cpu_en_q;
                OFF_CMASK: rd_data[PRIO_W-1:0] = mask_q;
                OFF_CACK:  rd_data[ID_W-1:0]   = fwd ? best_id : SPURIOUS_ID;
                OFF_CRUN:  rd_data[PRIO_W-1:0] = run_prio;
                OFF_CHPP:  rd_data[ID_W-1:0]   = best_valid ? best_id : SPURIOUS_ID;
                default:   rd_data             = '0;
            endcase
        end else if (rd_off == OFF_DCTRL) begin
            rd_data[0] = dist_en_q;
        end else if (rd_off == OFF_DTYPE) begin
            rd_data[4:0] = 5'(NUM_WORDS - 1);
        end else begin
            case (rd_grp)
                GRP_SET_EN, GRP_CLR_EN:     rd_data = en_word;
                GRP_SET_PEND, GRP_CLR_PEND: rd_data = pd_word;
                GRP_CLR_ACT:                rd_data = act_word;
                GRP_PRIO:                   rd_data = prio_word;
                default:                    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic [12:0]          rd_addr,
    input logic [31:0]          rd_data,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] active_q,
    input logic                 dist_en_q,
    input logic                 cpu_en_q,
    input prio_t                mask_q,
    input prio_t                best_prio,
    input prio_t                run_prio
);
    localparam int IDX_W = $clog2(NUM_LINES);

    logic ack_hit, claim_seen;
    logic [IDX_W-1:0] claim_idx_q;

    assign ack_hit    = rd_en && rd_addr == {1'b1, OFF_CACK};
    assign claim_seen = ack_hit && rd_data[ID_W-1:0] != SPURIOUS_ID;

    always_ff @(posedge clk) begin
        if (rst) claim_idx_q <= '0;
        else if (claim_seen) claim_idx_q <= rd_data[IDX_W-1:0];
    end

    AST_ACK_FORMAT: assert property (@(posedge clk) disable iff (rst)
        ack_hit |-> (rd_data[31:ID_W] == '0 &&
                     (rd_data[ID_W-1:0] == SPURIOUS_ID || rd_data[ID_W-1:0] < ID_W'(NUM_LINES)))); // R7

    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && rd_data[ID_W-1:0] == SPURIOUS_ID) |-> !irq_out); // R7

    AST_CLAIM_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        claim_seen |=> active_q[claim_idx_q]); // R7

    AST_NO_RECLAIM: assert property (@(posedge clk) disable iff (rst)
        claim_seen |-> !active_q[rd_data[IDX_W-1:0]]); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (dist_en_q && cpu_en_q && best_prio < mask_q && best_prio < run_prio)); // R5

    AST_RUN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (active_q == '0) |-> (run_prio == PRIO_IDLE)); // R9

endmodule

bind irq_distributor irqd_checker #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq_out   (irq_out),
    .active_q  (active_q),
    .dist_en_q (dist_en_q),
    .cpu_en_q  (cpu_en_q),
    .mask_q    (mask_q),
    .best_prio (best_prio),
    .run_prio  (run_prio)
);

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb_top;

    localparam int NL = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_lines = '0;
    logic          wr_en = 1'b0;
    logic [12:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [12:0]   rd_addr = '0;
    logic [31:0]   rd_data;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_distributor #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_out(irq_out)
    );

    // arbitration table: line pattern and expected highest-pending ID
    localparam logic [63:0] TV_LINES [7] = '{
        64'h0000_0000_0000_0004,
        64'h0000_0000_0000_0204,
        64'h0000_0000_0000_0024,
        64'h0000_0100_0000_0020,
        64'h8000_0100_0000_0020,
        64'h0000_0000_0000_0000,
        64'h0000_0002_0000_0000
    };
    localparam int TV_ID [7] = '{2, 2, 5, 5, 63, 1023, 33};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [12:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [12:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] prio_word(input int q);
        case (q)
            1:       return 32'h8080_2080; // line 5 = 0x20
            8:       return 32'h8080_FF80; // line 33 = 0xFF
            10:      return 32'h8080_8020; // line 40 = 0x20
            15:      return 32'h1080_8080; // line 63 = 0x10
            default: return 32'h8080_8080;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        #1 check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        do_rd(13'h1014, v); check("R1 running prio", v, 32'hFF);
        do_rd(13'h100C, v); check("R1 ack", v, 32'h3FF);
        do_rd(13'h1004, v); check("R1 mask", v, 32'h0);
        do_rd(13'h0100, v); check("R1 enable", v, 32'h0);

        // R2 type
        do_rd(13'h0004, v); check("R2 type", v, 32'd1);

        // R3 set/clear enable
        do_wr(13'h0100, 32'h11);
        do_rd(13'h0100, v); check("R3 set-en", v, 32'h11);
        do_rd(13'h0180, v); check("R3 clr-en readback", v, 32'h11);
        do_wr(13'h0100, 32'h0);
        do_rd(13'h0100, v); check("R3 zero set", v, 32'h11);
        do_wr(13'h0180, 32'h1);
        do_rd(13'h0100, v); check("R3 clr-en", v, 32'h10);
        do_wr(13'h0180, 32'h0);
        do_rd(13'h0100, v); check("R3 zero clear", v, 32'h10);

        // setup
        for (int q = 0; q < NL / 4; q++) do_wr(13'(32'h400 + 4 * q), prio_word(q));
        do_wr(13'h0100, 32'hFFFF_FFFF);
        do_wr(13'h0104, 32'hFFFF_FFFF);
        do_wr(13'h0000, 32'h1);
        do_wr(13'h1000, 32'h1);
        do_wr(13'h1004, 32'hFF);

        // R4 priority lanes
        do_rd(13'h0404, v); check("R4 prio word1", v, 32'h8080_2080);
        do_rd(13'h043C, v); check("R4 prio word15", v, 32'h1080_8080);

        // R6 / R12 table walk
        for (int i = 0; i < 7; i++) begin
            irq_lines = TV_LINES[i];
            do_rd(13'h1018, v); check("R6 R12 highest pending", v, 32'(TV_ID[i]));
            check("R5 irq_out table", {31'd0, irq_out},
                  {31'd0, (TV_ID[i] != 1023 && TV_ID[i] != 33)});
        end

        // R5 gating
        irq_lines = 64'h20;
        do_wr(13'h1004, 32'h20);
        #1 check("R5 mask equal blocks", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        do_wr(13'h1004, 32'h21);
        #1 check("R5 mask above passes", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        do_wr(13'h0000, 32'h0);
        #1 check("R5 dist off", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        do_wr(13'h0000, 32'h1);
        do_wr(13'h1000, 32'h0);
        #1 check("R5 cpu off", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        do_rd(13'h100C, v); check("R7 ack with cpu off", v, 32'h3FF);
        do_wr(13'h1000, 32'h1);
        do_wr(13'h1004, 32'hFF);

        // R7 claim
        do_rd(13'h100C, v); check("R7 claim id", v, 32'd5);
        do_rd(13'h1014, v); check("R9 running prio", v, 32'h20);
        #1 check("R8 active not forwarded", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        do_rd(13'h100C, v); check("R8 no reclaim", v, 32'h3FF);

        // R5 running priority gating
        irq_lines = 64'h24;
        #1 check("R5 less urgent held", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        do_rd(13'h1018, v); check("R12 hpp ignores running", v, 32'd2);
        irq_lines = 64'h8000_0000_0000_0024;
        #1 check("R5 more urgent passes", {31'd0, irq_out}, 32'd1);
        @(negedge clk);

        // R8 out-of-range release
        do_wr(13'h1010, 32'd100);
        do_rd(13'h1014, v); check("R8 eoi out of range", v, 32'h20);

        // R13 claim and release in one cycle
        wr_en = 1'b1; wr_addr = 13'h1010; wr_data = 32'd5;
        rd_en = 1'b1; rd_addr = 13'h100C;
        #1 v = rd_data;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R13 same-cycle claim id", v, 32'd63);
        do_rd(13'h1014, v); check("R13 running after overlap", v, 32'h10);
        do_rd(13'h0380, v); check("R13 active word0", v, 32'h0);
        do_rd(13'h0384, v); check("R13 active word1", v, 32'h8000_0000);

        // R11 clear-active
        do_wr(13'h0384, 32'h8000_0000);
        do_rd(13'h1014, v); check("R11 clear active", v, 32'hFF);
        do_rd(13'h100C, v); check("R11 reclaim after clear", v, 32'd63);
        do_wr(13'h1010, 32'd63);
        do_rd(13'h1014, v); check("R8 eoi releases", v, 32'hFF);

        // R10 software pending
        irq_lines = '0;
        do_wr(13'h0200, 32'h200);
        do_rd(13'h0200, v); check("R10 sw set", v, 32'h200);
        do_rd(13'h100C, v); check("R10 sw claim", v, 32'd9);
        do_rd(13'h0200, v); check("R10 claim clears latch", v, 32'h0);
        do_wr(13'h1010, 32'd9);
        do_wr(13'h0200, 32'h8);
        do_wr(13'h0280, 32'h8);
        do_rd(13'h0200, v); check("R10 sw clear", v, 32'h0);
        #1 check("R10 nothing pending", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        irq_lines = 64'h80;
        do_rd(13'h0200, v); check("R10 level visible", v, 32'h80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule